// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one external machine cycle at a time for an 8-bit processor core on a bus where the low address byte and the data share the same pins. The core presents a request that carries a three-bit cycle code, a 16-bit address and write data. The controller then steps through its T states. It drives the upper address byte and the shared low byte, pulses ALE, raises the read or write strobe, and holds the cycle status lines steady for the whole cycle. When the target is slow it adds whole wait clocks. For a read it hands the captured byte back to the core with a one-clock valid pulse.

A second bus master can ask for the bus with `hold`. The controller finishes the transfer in progress and raises `hlda`. From the next clock it floats every bus output. When `hold` drops, it waits one clock before it drives the bus again. A halt input also floats the bus and shows the halt status. The pins are not modelled as inout. Three output enables (address, shared address/data, control) tell the pad ring which groups are driven.

Top module: `mbus_bus_ctrl`

## Requirements
- R1: In the first T state of a cycle, `ale` is high for exactly one clock. In that clock `ad_out` carries `req_addr[7:0]` with `ad_oe`=1, and `addr_hi` carries `req_addr[15:8]` with `addr_oe`=1.
- R2: The cycle code is placed on {`io_m`,`s1`,`s0`}. Legal codes are 001 memory write, 010 memory read, 101 I/O write, 110 I/O read, 011 opcode fetch and 111 interrupt acknowledge. Codes with `s1`=1 are reads. Codes with `s1`=0 and `s0`=1 are writes.
- R3: {`io_m`,`s1`,`s0`} keep the cycle code from T1 through the last T state, wait states included.
- R4: For a read, `rd_n` is low in T2 and in every wait state and high in T3, and `ad_oe` is 0 from T2 on. `rd_n` and `wr_n` are never low together.
- R5: For a write, `wr_n` is low in T2 and in every wait state. `ad_out` holds the write data with `ad_oe`=1 from T2 through T3, and `wr_n` is already high in T3 while that data is still driven.
- R6: Every clock edge that ends T2 or a wait state with `ready` low adds one more wait state. With `ready` high the cycle moves to T3.
- R7: Read data on `ad_in` is captured at the edge that samples `ready` high. It appears on `rsp_data` with `rsp_valid` high for exactly the T3 clock. Writes never raise `rsp_valid`.
- R8: A request with code 000 or 100 is consumed and starts no cycle (`ale` stays low).
- R9: `hold` is granted only between transfers. In the first clock of the grant `hlda`=1 and the bus is still driven. From the next clock on, `addr_oe`, `ad_oe` and `ctrl_oe` are 0 while `hlda` stays 1.
- R10: After `hold` is seen low, `hlda` falls. In that clock no group is driven. In the clock after it, `addr_oe` and `ctrl_oe` are 1 again.
- R11: While `halt` is high and no request or hold is pending, all three enables are 0, `s1`=`s0`=0, `ale`=0, and `req_ready`=0.
- R12: While `rst_n` is low, all three enables, `ale` and `hlda` are 0.
- R13: `req_ready` is 1 only when idle or in T3 and `hold` is low. A request is taken on a clock edge where both `req_valid` and `req_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_code | input | 3 | Cycle code {io_m,s1,s0} |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request taken this edge if valid |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | 8 | Captured read data |
| halt | input | 1 | Core halted |
| ready | input | 1 | Target ready, sampled at end of T2/wait |
| hold | input | 1 | Other master requests the bus |
| hlda | output | 1 | Hold acknowledge |
| ale | output | 1 | Address latch strobe |
| addr_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Multiplexed low address / write data out |
| ad_in | input | 8 | Multiplexed bus read data in |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_oe | output | 1 | Drive enable for addr_hi |
| ad_oe | output | 1 | Drive enable for ad_out |
| ctrl_oe | output | 1 | Drive enable for rd_n, wr_n, io_m |

## Verification
A hold request and the end of a bus transfer can land in the same clock. `hold` rises during T2 or a wait state just as `ready` goes high, so the sequencer must finish T3, the read-data pulse included, before it grants. The bench provokes this by raising `hold` in T2 of directed cycles with zero and several wait states. It judges the result by checking that T3 still carries the strobe and data behaviour and that `hlda` rises only in the clock after T3, with the bus still driven. In the clock after that, every enable must be off.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_HALT,
        ST_HGNT,
        ST_HOLD,
        ST_HREL
    } bus_state_e;

    localparam logic [2:0] CODE_MEM_WR = 3'b001;
    localparam logic [2:0] CODE_MEM_RD = 3'b010;
    localparam logic [2:0] CODE_IO_WR  = 3'b101;
    localparam logic [2:0] CODE_IO_RD  = 3'b110;
    localparam logic [2:0] CODE_FETCH  = 3'b011;
    localparam logic [2:0] CODE_INTA   = 3'b111;

    // s1 set means data flows toward the core
    function automatic logic code_reads(input logic [2:0] c);
        return c[1];
    endfunction

    function automatic logic code_writes(input logic [2:0] c);
        return c[0] & ~c[1];
    endfunction

    function automatic logic code_legal(input logic [2:0] c);
        return c[1:0] != 2'b00;
    endfunction

endpackage

// File: rtl/mbus_kind_dec.sv
module mbus_kind_dec
    import mbus_pkg::*;
(
    input  logic [2:0] code,
    output logic       is_rd,
    output logic       is_wr
);
    always_comb begin
        is_rd = code_reads(code);
        is_wr = code_writes(code);
    end
endmodule

// File: rtl/mbus_seq.sv
module mbus_seq
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_code,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          halt,
    input  logic          ready,
    input  logic          hold,
    input  logic [DW-1:0] ad_in,
    output bus_state_e    state,
    output logic [2:0]    cur_code,
    output logic [AW-1:0] cur_addr,
    output logic [DW-1:0] cur_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data
);
    typedef struct packed {
        bus_state_e    st;
        logic [2:0]    code;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic          rvalid;
    } seq_t;

    seq_t seq_d, seq_q;
    logic take;

    always_comb begin
        seq_d        = seq_q;
        seq_d.rvalid = 1'b0;
        req_ready    = ((seq_q.st == ST_IDLE) || (seq_q.st == ST_T3)) && !hold;
        take         = req_valid && req_ready;

        case (seq_q.st)
            ST_IDLE, ST_T3: begin
                if (hold) begin
                    seq_d.st = ST_HGNT;
                end else if (take) begin
                    if (code_legal(req_code)) begin
                        seq_d.st    = ST_T1;
                        seq_d.code  = req_code;
                        seq_d.addr  = req_addr;
                        seq_d.wdata = req_wdata;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end else if (halt) begin
                    seq_d.st = ST_HALT;
                end else begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_HALT: begin
                if (hold)       seq_d.st = ST_HGNT;
                else if (!halt) seq_d.st = ST_IDLE;
            end
            ST_T1: seq_d.st = ST_T2;
            ST_T2, ST_TW: begin
                if (ready) begin
                    seq_d.st = ST_T3;
                    if (code_reads(seq_q.code)) begin
                        seq_d.rdata  = ad_in;
                        seq_d.rvalid = 1'b1;
                    end
                end else begin
                    seq_d.st = ST_TW;
                end
            end
            ST_HGNT: seq_d.st = ST_HOLD;
            ST_HOLD: begin
                if (!hold) seq_d.st = ST_HREL;
            end
            ST_HREL: seq_d.st = ST_IDLE;
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st     <= ST_IDLE;
            seq_q.code   <= '0;
            seq_q.addr   <= '0;
            seq_q.wdata  <= '0;
            seq_q.rdata  <= '0;
            seq_q.rvalid <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state     = seq_q.st;
    assign cur_code  = seq_q.code;
    assign cur_addr  = seq_q.addr;
    assign cur_wdata = seq_q.wdata;
    assign rsp_valid = seq_q.rvalid;
    assign rsp_data  = seq_q.rdata;
endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          rst_n,
    input  bus_state_e    state,
    input  logic [2:0]    cur_code,
    input  logic [AW-1:0] cur_addr,
    input  logic [DW-1:0] cur_wdata,
    output logic          hlda,
    output logic          ale,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    output logic          io_m,
    output logic          s1,
    output logic          s0,
    output logic          rd_n,
    output logic          wr_n,
    output logic          addr_oe,
    output logic          ad_oe,
    output logic          ctrl_oe
);
    logic is_rd, is_wr;
    logic a_en, d_en, c_en;

    mbus_kind_dec u_dec (
        .code  (cur_code),
        .is_rd (is_rd),
        .is_wr (is_wr)
    );

    always_comb begin
        hlda   = 1'b0;
        ale    = 1'b0;
        ad_out = '0;
        {io_m, s1, s0} = 3'b000;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        a_en   = 1'b1;
        d_en   = 1'b0;
        c_en   = 1'b1;

        case (state)
            ST_T1: begin
                ale    = 1'b1;
                d_en   = 1'b1;
                ad_out = cur_addr[DW-1:0];
                {io_m, s1, s0} = cur_code;
            end
            ST_T2, ST_TW: begin
                {io_m, s1, s0} = cur_code;
                rd_n   = ~is_rd;
                wr_n   = ~is_wr;
                d_en   = is_wr;
                ad_out = is_wr ? cur_wdata : '0;
            end
            ST_T3: begin
                {io_m, s1, s0} = cur_code;
                d_en   = is_wr;
                ad_out = is_wr ? cur_wdata : '0;
            end
            ST_HGNT: hlda = 1'b1;
            ST_HOLD: begin
                hlda = 1'b1;
                a_en = 1'b0;
                c_en = 1'b0;
            end
            ST_HALT, ST_HREL: begin
                a_en = 1'b0;
                c_en = 1'b0;
            end
            default: ;
        endcase
    end

    assign addr_hi = cur_addr[AW-1:DW];
    assign addr_oe = a_en & rst_n;
    assign ad_oe   = d_en & rst_n;
    assign ctrl_oe = c_en & rst_n;
endmodule

// File: rtl/mbus_bus_ctrl.sv
module mbus_bus_ctrl
    import mbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_code,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    input  logic          halt,
    input  logic          ready,
    input  logic          hold,
    output logic          hlda,
    output logic          ale,
    output logic [AW-DW-1:0] addr_hi,
    output logic [DW-1:0] ad_out,
    input  logic [DW-1:0] ad_in,
    output logic          io_m,
    output logic          s1,
    output logic          s0,
    output logic          rd_n,
    output logic          wr_n,
    output logic          addr_oe,
    output logic          ad_oe,
    output logic          ctrl_oe
);
    bus_state_e    state;
    logic [2:0]    cur_code;
    logic [AW-1:0] cur_addr;
    logic [DW-1:0] cur_wdata;

    mbus_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_code  (req_code),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .halt      (halt),
        .ready     (ready),
        .hold      (hold),
        .ad_in     (ad_in),
        .state     (state),
        .cur_code  (cur_code),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    mbus_pin_drv #(.AW(AW), .DW(DW)) u_drv (
        .rst_n     (rst_n),
        .state     (state),
        .cur_code  (cur_code),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .hlda      (hlda),
        .ale       (ale),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .io_m      (io_m),
        .s1        (s1),
        .s0        (s0),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr_oe   (addr_oe),
        .ad_oe     (ad_oe),
        .ctrl_oe   (ctrl_oe)
    );
endmodule

// File: rtl/mbus_ctrl_chk.sv
module mbus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic hold,
    input logic req_ready,
    input logic rsp_valid,
    input logic hlda,
    input logic ale,
    input logic io_m,
    input logic s1,
    input logic s0,
    input logic rd_n,
    input logic wr_n,
    input logic addr_oe,
    input logic ad_oe,
    input logic ctrl_oe
);
    p_ale_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_ale_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (addr_oe && ad_oe));

    p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> $stable({io_m, s1, s0}));

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_oe |-> (rd_n || wr_n));

    p_wr_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_oe && !wr_n) |-> ad_oe);

    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_hold_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && $past(hlda)) |-> (!addr_oe && !ad_oe && !ctrl_oe));

    p_release_float_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda) |-> (!addr_oe && !ad_oe && !ctrl_oe));

    p_take_gate_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !hold);

    always_comb begin
        if (rst_n === 1'b0) begin
            p_reset_float_r12: assert (!addr_oe && !ad_oe && !ctrl_oe && !hlda && !ale);
        end
    end
endmodule

bind mbus_bus_ctrl mbus_ctrl_chk u_chk (.*);

// File: tb/sim_mbus_bus_ctrl.sv
module sim_mbus_bus_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_code = 3'b000;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       req_ready, rsp_valid;
    logic [7:0] rsp_data;
    logic       halt = 1'b0, ready = 1'b1, hold = 1'b0;
    logic       hlda, ale, io_m, s1, s0, rd_n, wr_n, addr_oe, ad_oe, ctrl_oe;
    logic [7:0] addr_hi, ad_out;
    logic [7:0] ad_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mbus_bus_ctrl u0 (.*);

    function automatic logic [2:0] pick_code(input int idx);
        case (idx % 6)
            0: return 3'b001;
            1: return 3'b010;
            2: return 3'b101;
            3: return 3'b110;
            4: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic bit exp_rd(input logic [2:0] c);
        return c[1];
    endfunction

    function automatic bit exp_wr(input logic [2:0] c);
        return c[0] && !c[1];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // one full cycle; hold_mid raises hold in T2
    task automatic run_cycle(input logic [2:0] code, input logic [15:0] addr,
                             input logic [7:0] wd, input logic [7:0] rdv,
                             input int nw, input bit hold_mid);
        @(negedge clk);
        chk_eq("R7 rsp_valid low between cycles", {31'b0, rsp_valid}, 0);
        chk_eq("R13 req_ready idle", {31'b0, req_ready}, 1);
        req_valid = 1'b1; req_code = code; req_addr = addr; req_wdata = wd;
        @(negedge clk); // T1
        req_valid = 1'b0;
        chk_eq("R1 ale in T1", {31'b0, ale}, 1);
        chk_eq("R1 low addr on ad", {23'b0, ad_oe, ad_out}, {23'b0, 1'b1, addr[7:0]});
        chk_eq("R1 high addr", {23'b0, addr_oe, addr_hi}, {23'b0, 1'b1, addr[15:8]});
        chk_eq("R2 status code", {29'b0, io_m, s1, s0}, {29'b0, code});
        @(negedge clk); // T2
        chk_eq("R1 ale single", {31'b0, ale}, 0);
        chk_eq("R3 status T2", {29'b0, io_m, s1, s0}, {29'b0, code});
        chk_eq("R4 rd_n T2", {31'b0, rd_n}, {31'b0, !exp_rd(code)});
        chk_eq("R5 wr_n T2", {31'b0, wr_n}, {31'b0, !exp_wr(code)});
        chk_eq("R4 R5 ad_oe T2", {31'b0, ad_oe}, {31'b0, exp_wr(code)});
        if (exp_wr(code)) chk_eq("R5 wdata T2", {24'b0, ad_out}, {24'b0, wd});
        ad_in = rdv;
        ready = (nw == 0);
        if (hold_mid) hold = 1'b1;
        for (int i = 0; i < nw; i++) begin
            @(negedge clk); // TW
            chk_eq("R6 strobe held in wait", {30'b0, rd_n, wr_n},
                   {30'b0, !exp_rd(code), !exp_wr(code)});
            chk_eq("R3 status in wait", {29'b0, io_m, s1, s0}, {29'b0, code});
            chk_eq("R7 no early rsp", {31'b0, rsp_valid}, 0);
            ready = (i == nw - 1);
        end
        @(negedge clk); // T3
        chk_eq("R7 rsp_valid T3", {31'b0, rsp_valid}, {31'b0, exp_rd(code)});
        if (exp_rd(code)) chk_eq("R7 rsp_data", {24'b0, rsp_data}, {24'b0, rdv});
        chk_eq("R4 R5 strobes high T3", {30'b0, rd_n, wr_n}, {30'b0, 2'b11});
        chk_eq("R5 data held T3", {31'b0, ad_oe}, {31'b0, exp_wr(code)});
        if (exp_wr(code)) chk_eq("R5 wdata T3", {24'b0, ad_out}, {24'b0, wd});
        chk_eq("R3 status T3", {29'b0, io_m, s1, s0}, {29'b0, code});
        chk_eq("R13 req_ready T3", {31'b0, req_ready}, {31'b0, !hold});
        ready = 1'b1;
    endtask

    task automatic hold_phase(input int len);
        @(negedge clk); // grant clock
        chk_eq("R9 hlda rises", {31'b0, hlda}, 1);
        chk_eq("R9 bus still driven", {30'b0, addr_oe, ctrl_oe}, {30'b0, 2'b11});
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            chk_eq("R9 hlda held", {31'b0, hlda}, 1);
            chk_eq("R9 bus floated", {29'b0, addr_oe, ad_oe, ctrl_oe}, 0);
            req_valid = 1'b1; req_code = 3'b010;
            chk_eq("R13 no take in hold", {31'b0, req_ready}, 0);
        end
        hold = 1'b0;
        @(negedge clk); // release clock
        req_valid = 1'b0;
        chk_eq("R10 hlda falls", {31'b0, hlda}, 0);
        chk_eq("R10 float on release", {29'b0, addr_oe, ad_oe, ctrl_oe}, 0);
        @(negedge clk);
        chk_eq("R10 drive resumes", {30'b0, addr_oe, ctrl_oe}, {30'b0, 2'b11});
        chk_eq("R8 no cycle from stale request", {31'b0, ale}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk_eq("R12 enables off in reset", {29'b0, addr_oe, ad_oe, ctrl_oe}, 0);
        chk_eq("R12 ale hlda low in reset", {30'b0, ale, hlda}, 0);
        rst_n = 1'b1;

        // each code once, directed
        for (int k = 0; k < 6; k++)
            run_cycle(pick_code(k), 16'hA55A ^ 16'(k * 16'h1111), 8'(8'h3C + k), 8'(8'hC3 - k), k % 3, 1'b0);

        // illegal codes
        @(negedge clk);
        req_valid = 1'b1; req_code = 3'b100; req_addr = 16'h1234;
        @(negedge clk);
        req_code = 3'b000;
        chk_eq("R8 code 100 dropped", {31'b0, ale}, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk_eq("R8 code 000 dropped", {31'b0, ale}, 0);
        @(negedge clk);
        chk_eq("R8 still idle", {31'b0, ale}, 0);

        // hold meeting transfer end, no waits and with waits
        run_cycle(3'b010, 16'h0F0F, 8'h00, 8'h5A, 0, 1'b1);
        hold_phase(3);
        run_cycle(3'b001, 16'hF00F, 8'h99, 8'h00, 3, 1'b1);
        hold_phase(1);

        // hold from idle
        @(negedge clk);
        hold = 1'b1;
        hold_phase(2);

        // halt
        @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        chk_eq("R11 float in halt", {29'b0, addr_oe, ad_oe, ctrl_oe}, 0);
        chk_eq("R11 halt status", {29'b0, s1, s0, ale}, 0);
        chk_eq("R11 no take in halt", {31'b0, req_ready}, 0);
        halt = 1'b0;
        @(negedge clk);
        chk_eq("R11 leave halt", {30'b0, addr_oe, ctrl_oe}, {30'b0, 2'b11});

        // random traffic
        for (int n = 0; n < 60; n++)
            run_cycle(pick_code(int'($urandom % 6)), 16'($urandom), 8'($urandom),
                      8'($urandom), int'($urandom % 4), 1'b0);

        @(negedge clk);
        chk_eq("R7 pulse ends", {31'b0, rsp_valid}, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule